// File: doc/BRIEF.md
# Smart card character transmitter with transmit status flags

This block drives the transmit direction of a half-duplex smart card link. A byte handed to it is sent on the shared I/O line as one character of ten bits, each one elementary time unit (etu) long. The character is a low start bit, eight data bits with the least significant bit first, and an even parity bit. Between characters the line rests high. Once the parity bit has gone out, the block listens to the line for one etu. A receiver that saw a parity error pulls the line low during that etu, and the block records this.

Three status flags tell the controlling processor or a DMA engine what the transmitter is doing. The data-empty flag shows that the holding register can take a new byte. The error flag records a low error pulse from the receiver. The end flag shows that the last character finished cleanly, and it is raised 2.5 etu after the parity bit. Software clears a flag in two steps: it reads the flag while the flag is 1, and then writes 0 to it. A DMA write to the data register loads a byte and clears the empty and end flags in the same step. The length of one etu is given in system clocks through an input.

Top module: `sc_char_tx`

## Requirements
- R1: A character occupies `etu_len` clocks per bit (`etu_len` of at least 1; 0 acts as 1). It is a 0 start bit, then the data bits with the LSB first, then a parity bit that makes the number of ones in data plus parity even. The line stays high at all other times.
- R2: A character starts only when `tx_en` is 1 and a byte is pending, which means `tdre` is 0. The line goes low one clock after both hold, and `tdre` returns to 1 in that same clock. While `tx_en` is 0, a pending byte waits and `tdre` stays 0.
- R3: While `tdre` is 0, a CPU data write or a DMA write is ignored. The pending byte is the one that gets sent.
- R4: Let h = floor(etu_len/2). The line is sampled once, h clocks into the first etu after the parity bit. A low sample sets `ers` on the next clock. A high sample leaves `ers` at 0.
- R5: `ers` clears only through this sequence: a status read while `ers` is 1, then a status write with bit 1 at 0. A status write without that earlier read has no effect, and neither does writing 1.
- R6: Clearing `tx_en` leaves `ers` unchanged.
- R7: `tend` sets one clock after the point 2·etu_len + h clocks past the end of the parity bit, but only if `tdre` is 1 and `ers` is 0 at that point. If `ers` is 1, `tend` stays 0.
- R8: While `tx_en` is 0 and `ers` is 0, `tend` is set on the next clock.
- R9: `tdre` and `tend` both clear in either of two ways: a status read while `tdre` is 1 followed by a status write with bit 0 at 0, or a DMA write while `tdre` is 1. A status write of bit 0 at 0 without that read has no effect.
- R10: Reset or `standby` stops any character in progress, drives the line high, sets `tdre` and `tend` to 1, and clears `ers` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Standby request; acts as a synchronous flag reset and aborts the character |
| tx_en | input | 1 | Transmit enable |
| etu_len | input | ETU_W | Clocks per etu |
| dat_wr | input | 1 | CPU write strobe for the data holding register |
| dat_wdata | input | DATA_W | CPU write data |
| stat_rd | input | 1 | Status read strobe; arms the clear of each flag that reads as 1 |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 2 | Status write data: bit 0 is for `tdre`, bit 1 is for `ers` |
| dma_wr | input | 1 | DMA write strobe for the data holding register |
| dma_wdata | input | DATA_W | DMA write data |
| line_in | input | 1 | Level sampled on the shared I/O line |
| line_out | output | 1 | Level driven toward the shared I/O line |
| tdre | output | 1 | Data holding register empty |
| tend | output | 1 | Transmission end |
| ers | output | 1 | Error signal seen |

## Verification
The assertions check on every cycle how the flags may move. `ers` changes only at the sample point, on a status write, or in standby. `tend` can rise only while `ers` was 0, and it can fall only after a DMA write or a status write. `tdre` rises only when a character starts or in standby, the pending byte stays fixed while `tdre` is 0, every character opens with a low line, and the sequencer returns to idle only at the end point. What only the bench's scenarios can show is the bit-exact content of each character and the exact clocks at which `ers` and `tend` change, across many etu lengths. They also show that writes and non-armed clears are ignored, that a pending byte survives `tx_en` being low, and that standby in the middle of a character clears the flags.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;
    // Status write data bit positions
    localparam int STAT_TDRE_BIT = 0;
    localparam int STAT_ERS_BIT  = 1;

    // Guard period offsets (in etu after the parity bit)
    localparam int GUARD_SAMPLE_OFS = 0;
    localparam int GUARD_DONE_OFS   = 2;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_BITS,
        PH_GUARD
    } phase_e;
endpackage

// File: rtl/sc_etu_seq.sv
module sc_etu_seq
    import sc_tx_pkg::*;
#(
    parameter int ETU_W      = 16,
    parameter int FRAME_BITS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic             start,
    input  logic [ETU_W-1:0] etu_len,
    output logic             active,
    output logic             in_frame,
    output logic             bit_end,
    output logic             sample_pt,
    output logic             done_pt
);
    localparam int IDX_W = $clog2(FRAME_BITS + GUARD_DONE_OFS + 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] IDX_SAMP = IDX_W'(FRAME_BITS + GUARD_SAMPLE_OFS);
    localparam logic [IDX_W-1:0] IDX_DONE = IDX_W'(FRAME_BITS + GUARD_DONE_OFS);
    localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);
    localparam logic [ETU_W-1:0] CNT_ONE  = ETU_W'(1);

    typedef struct packed {
        phase_e           ph;
        logic [ETU_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t seq_q, seq_d;
    logic [ETU_W-1:0] etu_eff, etu_last, etu_half;
    logic             cnt_wrap;

    always_comb begin
        etu_eff   = (etu_len == '0) ? CNT_ONE : etu_len;
        etu_last  = etu_eff - CNT_ONE;
        etu_half  = etu_eff >> 1;
        cnt_wrap  = (seq_q.cnt >= etu_last);
        in_frame  = (seq_q.ph == PH_BITS);
        active    = (seq_q.ph != PH_IDLE);
        bit_end   = in_frame && cnt_wrap;
        sample_pt = (seq_q.ph == PH_GUARD) && (seq_q.idx == IDX_SAMP) && (seq_q.cnt == etu_half);
        done_pt   = (seq_q.ph == PH_GUARD) && (seq_q.idx == IDX_DONE) && (seq_q.cnt == etu_half);

        seq_d = seq_q;
        unique case (seq_q.ph)
            PH_IDLE: begin
                if (start) begin
                    seq_d.ph  = PH_BITS;
                    seq_d.cnt = '0;
                    seq_d.idx = '0;
                end
            end
            PH_BITS: begin
                if (cnt_wrap) begin
                    seq_d.cnt = '0;
                    seq_d.idx = seq_q.idx + IDX_ONE;
                    if (seq_q.idx == IDX_LAST) begin
                        seq_d.ph = PH_GUARD;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_ONE;
                end
            end
            PH_GUARD: begin
                if (done_pt) begin
                    seq_d.ph  = PH_IDLE;
                    seq_d.cnt = '0;
                    seq_d.idx = '0;
                end else if (cnt_wrap) begin
                    seq_d.cnt = '0;
                    seq_d.idx = seq_q.idx + IDX_ONE;
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_ONE;
                end
            end
            default: seq_d.ph = PH_IDLE;
        endcase

        if (standby) begin
            seq_d.ph  = PH_IDLE;
            seq_d.cnt = '0;
            seq_d.idx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{ph: PH_IDLE, cnt: '0, idx: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    // R7: the sequencer leaves the guard period only at the end point
    a_r7_idle_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(active) && !$past(standby)) |-> $past(done_pt));
endmodule

// File: rtl/sc_tx_shift.sv
module sc_tx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              in_frame,
    input  logic              bit_end,
    output logic              line_out
);
    localparam int FRAME_BITS = DATA_W + 2;

    logic [FRAME_BITS-1:0] sh_q, sh_d;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d = {^din, din, 1'b0};
        end else if (bit_end) begin
            sh_d = {1'b1, sh_q[FRAME_BITS-1:1]};
        end
        line_out = in_frame ? sh_q[0] : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else begin
            sh_q <= sh_d;
        end
    end

    // R1: every character opens with a low start bit
    a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame) |-> !line_out);
endmodule

// File: rtl/sc_tx_flags.sv
module sc_tx_flags
    import sc_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              tx_en,
    input  logic              dat_wr,
    input  logic [DATA_W-1:0] dat_wdata,
    input  logic              stat_rd,
    input  logic              stat_wr,
    input  logic [1:0]        stat_wdata,
    input  logic              dma_wr,
    input  logic [DATA_W-1:0] dma_wdata,
    input  logic              seq_active,
    input  logic              sample_pt,
    input  logic              done_pt,
    input  logic              line_in,
    output logic              start,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tdre,
    output logic              tend,
    output logic              ers
);
    typedef struct packed {
        logic              tdre;
        logic              tend;
        logic              ers;
        logic              arm_tdre;
        logic              arm_ers;
        logic [DATA_W-1:0] hold;
    } flag_t;

    flag_t fl_q, fl_d;

    always_comb begin
        start = !fl_q.tdre && tx_en && !seq_active;
        fl_d  = fl_q;

        // Level condition for transmission end
        if (!tx_en && !fl_q.ers) begin
            fl_d.tend = 1'b1;
        end
        // End point of a character
        if (done_pt && fl_q.tdre && !fl_q.ers) begin
            fl_d.tend = 1'b1;
        end

        // Holding register loads, accepted only while empty
        if (fl_q.tdre) begin
            if (dat_wr) begin
                fl_d.hold = dat_wdata;
            end
            if (dma_wr) begin
                fl_d.hold = dma_wdata;
                fl_d.tdre = 1'b0;
                fl_d.tend = 1'b0;
            end
        end

        // Read-then-write-zero clear handshake
        if (stat_wr) begin
            if (fl_q.arm_tdre && !stat_wdata[STAT_TDRE_BIT]) begin
                fl_d.tdre = 1'b0;
                fl_d.tend = 1'b0;
            end
            if (fl_q.arm_ers && !stat_wdata[STAT_ERS_BIT]) begin
                fl_d.ers = 1'b0;
            end
            fl_d.arm_tdre = 1'b0;
            fl_d.arm_ers  = 1'b0;
        end
        if (stat_rd) begin
            fl_d.arm_tdre = fl_q.tdre;
            fl_d.arm_ers  = fl_q.ers;
        end

        // Byte moves into the shifter
        if (start) begin
            fl_d.tdre = 1'b1;
        end

        // Error pulse from the receiver
        if (sample_pt && !line_in) begin
            fl_d.ers = 1'b1;
        end

        if (standby) begin
            fl_d.tdre     = 1'b1;
            fl_d.tend     = 1'b1;
            fl_d.ers      = 1'b0;
            fl_d.arm_tdre = 1'b0;
            fl_d.arm_ers  = 1'b0;
        end

        tx_byte = fl_q.hold;
        tdre    = fl_q.tdre;
        tend    = fl_q.tend;
        ers     = fl_q.ers;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '{tdre: 1'b1, tend: 1'b1, ers: 1'b0,
                      arm_tdre: 1'b0, arm_ers: 1'b0, hold: '0};
        end else begin
            fl_q <= fl_d;
        end
    end

    // R2: empty flag returns only when a character starts or in standby
    a_r2_tdre_rise_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tdre) |-> ($past(start) || $past(standby)));

    // R3: the pending byte cannot change while the register is full
    a_r3_hold_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !tdre |=> $stable(tx_byte));

    // R6: ers moves only at the sample point, a status write or standby
    a_r6_ers_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_pt && !stat_wr && !standby) |=> $stable(ers));

    // R7: tend never rises while an error is flagged
    a_r7_tend_needs_clean: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tend) && !$past(standby)) |-> !$past(ers));

    // R9: tend falls only after a DMA write or a status write
    a_r9_tend_clear_source: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tend) |-> ($past(dma_wr) || $past(stat_wr)));
endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx
    import sc_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ETU_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              tx_en,
    input  logic [ETU_W-1:0]  etu_len,
    input  logic              dat_wr,
    input  logic [DATA_W-1:0] dat_wdata,
    input  logic              stat_rd,
    input  logic              stat_wr,
    input  logic [1:0]        stat_wdata,
    input  logic              dma_wr,
    input  logic [DATA_W-1:0] dma_wdata,
    input  logic              line_in,
    output logic              line_out,
    output logic              tdre,
    output logic              tend,
    output logic              ers
);
    localparam int FRAME_BITS = DATA_W + 2;

    logic              seq_active, in_frame, bit_end, sample_pt, done_pt;
    logic              start;
    logic [DATA_W-1:0] tx_byte;

    sc_etu_seq #(
        .ETU_W      (ETU_W),
        .FRAME_BITS (FRAME_BITS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby   (standby),
        .start     (start),
        .etu_len   (etu_len),
        .active    (seq_active),
        .in_frame  (in_frame),
        .bit_end   (bit_end),
        .sample_pt (sample_pt),
        .done_pt   (done_pt)
    );

    sc_tx_shift #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .din      (tx_byte),
        .in_frame (in_frame),
        .bit_end  (bit_end),
        .line_out (line_out)
    );

    sc_tx_flags #(
        .DATA_W (DATA_W)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby    (standby),
        .tx_en      (tx_en),
        .dat_wr     (dat_wr),
        .dat_wdata  (dat_wdata),
        .stat_rd    (stat_rd),
        .stat_wr    (stat_wr),
        .stat_wdata (stat_wdata),
        .dma_wr     (dma_wr),
        .dma_wdata  (dma_wdata),
        .seq_active (seq_active),
        .sample_pt  (sample_pt),
        .done_pt    (done_pt),
        .line_in    (line_in),
        .start      (start),
        .tx_byte    (tx_byte),
        .tdre       (tdre),
        .tend       (tend),
        .ers        (ers)
    );

    // R10: standby leaves the line high on the following clock
    a_r10_standby_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(standby) |-> (line_out && tdre && tend && !ers));
endmodule

// File: tb/sim_sc_char_tx.sv
module sim_sc_char_tx;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        standby, tx_en;
    logic [15:0] etu_len;
    logic        dat_wr, stat_rd, stat_wr, dma_wr;
    logic [7:0]  dat_wdata, dma_wdata;
    logic [1:0]  stat_wdata;
    logic        line_in, line_out, tdre, tend, ers;
    logic        pull;

    int checks = 0;
    int errors = 0;

    assign line_in = line_out & ~pull;

    sc_char_tx u0 (
        .clk(clk), .rst_n(rst_n), .standby(standby), .tx_en(tx_en),
        .etu_len(etu_len), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
        .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .dma_wr(dma_wr), .dma_wdata(dma_wdata), .line_in(line_in),
        .line_out(line_out), .tdre(tdre), .tend(tend), .ers(ers)
    );

    always #(CLK_NS/2) clk = ~clk;

    function automatic logic [9:0] frame_of(input logic [7:0] b);
        return {^b, b, 1'b0};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_data(input logic [7:0] b);
        dat_wr = 1'b1; dat_wdata = b; tick(); dat_wr = 1'b0;
    endtask

    task automatic wr_dma(input logic [7:0] b);
        dma_wr = 1'b1; dma_wdata = b; tick(); dma_wr = 1'b0;
    endtask

    task automatic rd_stat();
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
    endtask

    task automatic wr_stat(input logic t, input logic e);
        stat_wr = 1'b1; stat_wdata = {e, t}; tick(); stat_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Follows one character from its start bit to the end point
    task automatic watch_char(input logic [7:0] b, input bit err, input int etu, input bit tend_low_before);
        int h;
        logic [9:0] fr;
        h  = etu / 2;
        fr = frame_of(b);
        while (line_out) tick();
        chk("R2", "tdre at start", tdre, 1);
        for (int t = 0; t <= 12*etu + h + 1; t++) begin
            if (t > 0) tick();
            pull = err && (t >= 10*etu) && (t < 11*etu);
            if (t < 10*etu && (t % etu) == h)
                chk("R1", $sformatf("bit %0d", t/etu), line_out, fr[t/etu]);
            if (t == 10*etu + h)     chk("R4", "ers before sample", ers, 0);
            if (t == 10*etu + h + 1) chk("R4", "ers after sample", ers, err);
            if (t == 12*etu + h && tend_low_before) chk("R7", "tend before end point", tend, 0);
            if (t == 12*etu + h + 1) chk("R7", "tend after end point", tend, !err);
        end
        pull = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input bit err, input int etu, input bit via_dma);
        etu_len = 16'(etu);
        if (via_dma) begin
            wr_dma(b);
        end else begin
            wr_data(b);
            rd_stat();
            wr_stat(1'b0, 1'b1);
        end
        chk("R9", "tend cleared by load", tend, 0);
        chk("R9", "tdre cleared by load", tdre, 0);
        watch_char(b, err, etu, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; standby = 1'b0; tx_en = 1'b0; etu_len = 16'd4;
        dat_wr = 1'b0; stat_rd = 1'b0; stat_wr = 1'b0; dma_wr = 1'b0;
        dat_wdata = '0; dma_wdata = '0; stat_wdata = '0; pull = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R10", "reset tdre", tdre, 1);
        chk("R10", "reset tend", tend, 1);
        chk("R10", "reset ers", ers, 0);
        chk("R10", "reset line", line_out, 1);

        // Clean character through the CPU path, then error character through DMA
        tx_en = 1'b1;
        send(8'hA5, 1'b0, 4, 1'b0);
        send(8'h3C, 1'b1, 5, 1'b1);
        chk("R7", "tend held by error", tend, 0);

        // R5: write zero without prior read leaves ers
        wr_stat(1'b1, 1'b0);
        chk("R5", "ers after unarmed write", ers, 1);
        // R6: dropping tx_en keeps ers; tend held by ers
        tx_en = 1'b0;
        repeat (2) tick();
        chk("R6", "ers after tx_en low", ers, 1);
        chk("R8", "tend held while ers", tend, 0);
        rd_stat();
        wr_stat(1'b1, 1'b1);
        chk("R5", "ers after write one", ers, 1);
        rd_stat();
        wr_stat(1'b1, 1'b0);
        chk("R5", "ers after armed clear", ers, 0);
        tick();
        chk("R8", "tend with tx_en low", tend, 1);
        tx_en = 1'b1;

        // R9: unarmed tdre clear has no effect
        wr_stat(1'b0, 1'b1);
        tick();
        chk("R9", "tdre after unarmed write", tdre, 1);
        chk("R9", "tend after unarmed write", tend, 1);

        // R3 and R2: pending byte waits for tx_en and resists overwrites
        tx_en = 1'b0;
        wr_data(8'h11);
        rd_stat();
        wr_stat(1'b0, 1'b1);
        wr_data(8'h22);
        wr_dma(8'h33);
        repeat (4) tick();
        chk("R2", "pending byte waits", tdre, 0);
        chk("R2", "line idle while disabled", line_out, 1);
        etu_len = 16'd3;
        tx_en = 1'b1;
        watch_char(8'h11, 1'b0, 3, 1'b0);

        // Short etu corner
        send(8'h80, 1'b0, 1, 1'b1);

        // R10: standby in the middle of a character after an error
        send(8'h5A, 1'b1, 4, 1'b0);
        wr_dma(8'hF0);
        while (line_out) tick();
        repeat (9) tick();
        standby = 1'b1;
        tick();
        standby = 1'b0;
        chk("R10", "standby line", line_out, 1);
        chk("R10", "standby tdre", tdre, 1);
        chk("R10", "standby tend", tend, 1);
        chk("R10", "standby ers", ers, 0);
        repeat (6) tick();
        chk("R10", "no restart after standby", line_out, 1);

        // Random characters
        for (int i = 0; i < 30; i++) begin
            logic [7:0] b;
            bit e, d;
            int etu;
            b   = 8'($urandom);
            e   = ($urandom % 3) == 0;
            d   = ($urandom % 2) == 1;
            etu = 2 + int'($urandom % 8);
            if (ers) begin
                rd_stat();
                wr_stat(1'b1, 1'b0);
                chk("R5", "ers cleared before next", ers, 0);
            end
            send(b, e, etu, d);
        end

        finish_run();
    end
endmodule